// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a chain of 64-bit scatter-gather descriptors held in memory and turns each transfer descriptor into one address-and-length request for a separate data mover. Software, or a controlling state machine, gives it the byte address of the first descriptor and a one-cycle start pulse. The block then reads descriptors two words at a time through a simple read port and acts on each one. A descriptor either skips ahead, hands a transfer to the mover, or redirects the walk to a new address.

The walk ends on a descriptor marked as final, once that descriptor's own action has completed. The block then returns to idle with a one-cycle done pulse. If the final descriptor asks for it, a completion interrupt pulses in the same cycle. A descriptor that is not marked valid stops the walk at once with an error pulse. The memory read port completes a word in any cycle where the request and ready are both high, with the read data returned in that same cycle.

Top module: `sg_desc_walker`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `busy`, `mem_req`, `xfer_req`, `done`, `dma_irq` and `err` are all low.
- R2: A `start` pulse while idle latches `base_addr`. The first descriptor is then read as two words: word 0 (attributes and length) at `base_addr`, then word 1 (address) at `base_addr + 4`.
- R3: A `start` pulse while `busy` is high is ignored. The walk in progress and its read addresses are unchanged.
- R4: For word 0 bits 5:4 equal to 2 (transfer), the block raises `xfer_req` with `xfer_addr` = word 1 and `xfer_len` = word 0 bits 31:16. It holds these values and issues no memory read until `xfer_done` is seen. Lengths up to 65532 are passed through unchanged.
- R5: After a transfer descriptor, or a descriptor with action 0 or 1, that is not final, the next descriptor is read from the current descriptor address plus 8.
- R6: For action 3 (link), the next descriptor is read from the address held in word 1.
- R7: Actions 0 (no operation) and 1 (reserved) issue no transfer request.
- R8: A descriptor with word 0 bit 1 (final) set ends the walk after its action. This holds for a final link descriptor too, whose address is then not followed. `done` then pulses for exactly one cycle and `busy` falls in that same cycle.
- R9: `dma_irq` pulses together with `done` only when the final descriptor has word 0 bit 2 set. Bit 2 on a descriptor that is not final has no effect.
- R10: A descriptor with word 0 bit 0 (valid) clear stops the walk. `err` pulses for one cycle, the block goes idle, and neither a transfer request nor `done` is produced.
- R11: A memory read word is taken only in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, `mem_req` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a walk when idle |
| base_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High while a walk is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ready | input | 1 | Memory accepts the read and returns data this cycle |
| mem_rdata | input | 32 | Memory read data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_len | output | 16 | Transfer length in bytes |
| xfer_done | input | 1 | Data mover finished the current transfer |
| done | output | 1 | One-cycle pulse when a walk ends normally |
| dma_irq | output | 1 | One-cycle completion interrupt |
| err | output | 1 | One-cycle pulse on an invalid descriptor |

## Verification
Two events can land in the same cycle. One is the data mover's completion of the last transfer in a chain. The other is a new `start` pulse, which arrives while the engine is still busy in that cycle. The bench drives both in the same cycle. It expects the new start to be dropped: one `done`, no further memory read, and `busy` low afterwards. The same rule is also judged mid-walk, by pulsing `start` with a different base during the descriptor fetches and checking that the recorded read address sequence stays that of the original chain.

// File: rtl/sgw_pkg.sv
// Shared constants and types for the scatter-gather descriptor walker.
// Assumes the fixed 64-bit descriptor: two 32-bit words, attributes in word 0.
package sgw_pkg;
    localparam int WORD_W    = 32;
    localparam int BIT_VALID = 0;
    localparam int BIT_LAST  = 1;
    localparam int BIT_IRQ   = 2;
    localparam int ACT_LSB   = 4;
    localparam int LEN_LSB   = 16;

    typedef enum logic [1:0] {
        ACT_NOP  = 2'd0,
        ACT_RSVD = 2'd1,
        ACT_XFER = 2'd2,
        ACT_LINK = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LAUNCH, S_WAIT, S_EXEC, S_XFER
    } walk_st_e;
endpackage

// File: rtl/sgw_fetch.sv
// Two-word descriptor reader. On a go pulse it latches the descriptor address
// and reads word 0 then word 1 through the simple read port. It pulses
// `fetched` one cycle after word 1 is taken.
// Assumes data is returned in the cycle where mem_req and mem_ready are high.
module sgw_fetch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] word0,
    output logic [DATA_W-1:0] word1,
    output logic              fetched
);
    localparam int WORD_BYTES = DATA_W / 8;

    typedef enum logic [1:0] {F_IDLE, F_W0, F_W1} fph_e;

    fph_e              ph;
    logic [ADDR_W-1:0] addr_q;

    // Sequence the two reads and capture each word on its handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= F_IDLE;
            addr_q  <= '0;
            word0   <= '0;
            word1   <= '0;
            fetched <= 1'b0;
        end else begin
            fetched <= 1'b0;
            case (ph)
                F_IDLE: if (go) begin
                    addr_q <= desc_addr;
                    ph     <= F_W0;
                end
                F_W0: if (mem_ready) begin
                    word0 <= mem_rdata;
                    ph    <= F_W1;
                end
                F_W1: if (mem_ready) begin
                    word1   <= mem_rdata;
                    fetched <= 1'b1;
                    ph      <= F_IDLE;
                end
                default: ph <= F_IDLE;
            endcase
        end
    end

    // Drive the read request and pick the word offset.
    always_comb begin
        mem_req  = (ph != F_IDLE);
        mem_addr = (ph == F_W1) ? addr_q + ADDR_W'(WORD_BYTES) : addr_q;
    end
endmodule

// File: rtl/sgw_decode.sv
// Splits a fetched descriptor into its attribute, action, length and address
// fields. Purely combinational.
module sgw_decode
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output logic              d_valid,
    output logic              d_last,
    output logic              d_irq,
    output act_e              d_act,
    output logic [LEN_W-1:0]  d_len,
    output logic [ADDR_W-1:0] d_ptr
);
    // Pull each field out of its fixed position.
    always_comb begin
        d_valid = word0[BIT_VALID];
        d_last  = word0[BIT_LAST];
        d_irq   = word0[BIT_IRQ];
        d_act   = act_e'(word0[ACT_LSB +: 2]);
        d_len   = word0[LEN_LSB +: LEN_W];
        d_ptr   = word1[ADDR_W-1:0];
    end
endmodule

// File: rtl/sgw_next_addr.sv
// Chooses the next descriptor address: the link target for a link descriptor,
// otherwise the current address advanced by one descriptor.
module sgw_next_addr #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] link_ptr,
    input  logic              is_link,
    output logic [ADDR_W-1:0] next_addr
);
    // Select between sequential advance and redirection.
    always_comb begin
        next_addr = is_link ? link_ptr : cur_addr + ADDR_W'(DESC_BYTES);
    end
endmodule

// File: rtl/sg_desc_walker.sv
// Top of the scatter-gather descriptor walker. A walk starts from base_addr on
// a start pulse while idle. Each descriptor is fetched, decoded and then
// skipped, handed to the data mover or followed as a link. The walk ends on a
// final descriptor with done (and optionally dma_irq), or on an invalid
// descriptor with err.
// Assumes the data mover pulses xfer_done once per accepted request.
module sg_desc_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic              done,
    output logic              dma_irq,
    output logic              err
);
    localparam int DESC_BYTES = 2 * (WORD_W / 8);

    walk_st_e          st;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [WORD_W-1:0] w0, w1;
    logic              fetched;
    logic              d_valid, d_last, d_irq;
    act_e              d_act;
    logic [LEN_W-1:0]  d_len;
    logic [ADDR_W-1:0] d_ptr;

    sgw_fetch #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) fetch_i (
        .clk(clk), .rst_n(rst_n), .go(st == S_LAUNCH), .desc_addr(cur_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .word0(w0), .word1(w1), .fetched(fetched)
    );

    sgw_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) decode_i (
        .word0(w0), .word1(w1), .d_valid(d_valid), .d_last(d_last),
        .d_irq(d_irq), .d_act(d_act), .d_len(d_len), .d_ptr(d_ptr)
    );

    sgw_next_addr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) next_i (
        .cur_addr(cur_addr), .link_ptr(d_ptr),
        .is_link(d_act == ACT_LINK), .next_addr(nxt_addr)
    );

    // Walk state machine with one-cycle completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cur_addr <= '0;
            done     <= 1'b0;
            dma_irq  <= 1'b0;
            err      <= 1'b0;
        end else begin
            done    <= 1'b0;
            dma_irq <= 1'b0;
            err     <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    cur_addr <= base_addr;
                    st       <= S_LAUNCH;
                end
                S_LAUNCH: st <= S_WAIT;
                S_WAIT: if (fetched) st <= S_EXEC;
                S_EXEC: begin
                    if (!d_valid) begin
                        err <= 1'b1;
                        st  <= S_IDLE;
                    end else if (d_act == ACT_XFER) begin
                        st <= S_XFER;
                    end else if (d_last) begin
                        done    <= 1'b1;
                        dma_irq <= d_irq;
                        st      <= S_IDLE;
                    end else begin
                        cur_addr <= nxt_addr;
                        st       <= S_LAUNCH;
                    end
                end
                S_XFER: if (xfer_done) begin
                    if (d_last) begin
                        done    <= 1'b1;
                        dma_irq <= d_irq;
                        st      <= S_IDLE;
                    end else begin
                        cur_addr <= nxt_addr;
                        st       <= S_LAUNCH;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Present the transfer request and the busy indication.
    always_comb begin
        busy      = (st != S_IDLE);
        xfer_req  = (st == S_XFER);
        xfer_addr = d_ptr;
        xfer_len  = d_len;
    end
endmodule

// File: rtl/sgw_checker.sv
// Protocol checker for the descriptor walker, attached by bind.
module sgw_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              xfer_req,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              xfer_done,
    input logic              done,
    input logic              dma_irq,
    input logic              err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !xfer_req)); // R1
    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))); // R4
    AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !mem_req); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> done); // R9
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !busy)); // R10
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R11
endmodule

bind sg_desc_walker sgw_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .xfer_req(xfer_req),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .done(done), .dma_irq(dma_irq), .err(err)
);

// File: tb/sg_desc_walker_tb_top.sv
module sg_desc_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_m = 1'b0;
    logic        start_p = 1'b0;
    logic        start;
    logic [31:0] base_addr = '0;
    logic        busy, mem_req, mem_ready, xfer_req, xfer_done, done, dma_irq, err;
    logic [31:0] mem_addr, mem_rdata, xfer_addr;
    logic [15:0] xfer_len;
    logic [31:0] mem [64];

    int checks = 0, fails = 0, cyc = 0;
    int xn, rn, dn, irqn, errn, mv_cnt;
    logic [31:0] xa [8];
    logic [15:0] xl [8];
    logic [31:0] ra [32];
    bit poke_on_done = 1'b0;

    always #5 clk = ~clk;
    assign start = start_m | start_p;
    assign mem_rdata = mem[mem_addr[7:2]];
    assign xfer_done_w = 1'b0;
    logic xfer_done_w;

    sg_desc_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .done(done), .dma_irq(dma_irq), .err(err)
    );

    typedef struct packed {
        logic [31:0] w0;
        logic [31:0] w1;
        logic [3:0]  nx;
        logic [15:0] xlen;
        logic        dn;
        logic        irq;
        logic        er;
    } vec_t;

    // Single descriptors at 0x10: word0, word1, transfers, length, done, irq, err
    localparam vec_t VECS [6] = '{
        '{32'h0100_0027, 32'h8000_0000, 4'd1, 16'h0100, 1'b1, 1'b1, 1'b0},
        '{32'hFFFC_0023, 32'h1234_5678, 4'd1, 16'hFFFC, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0007, 32'h0000_0000, 4'd0, 16'h0000, 1'b1, 1'b1, 1'b0},
        '{32'h0000_0013, 32'h0000_0000, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0},
        '{32'h0100_0026, 32'h0000_9000, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1},
        '{32'h0000_0033, 32'h0000_0040, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory ready pattern, data mover model and event monitors.
    always @(negedge clk) begin
        cyc++;
        mem_ready = (cyc % 3) != 0;
        start_p = 1'b0;
        if (mem_req && mem_ready) begin
            if (rn < 32) ra[rn] = mem_addr;
            rn++;
        end
        if (done) dn++;
        if (dma_irq) irqn++;
        if (err) errn++;
        if (xfer_done) xfer_done = 1'b0;
        else if (mv_cnt > 0) begin
            mv_cnt--;
            if (mv_cnt == 0) begin
                xfer_done = 1'b1;
                if (poke_on_done) begin
                    start_p = 1'b1;
                    base_addr = 32'h30;
                end
            end
        end else if (xfer_req) begin
            if (xn < 8) begin
                xa[xn] = xfer_addr;
                xl[xn] = xfer_len;
            end
            xn++;
            mv_cnt = 3;
        end
    end

    task automatic run_chain(input logic [31:0] base, input bit mid_poke);
        xn = 0; rn = 0; dn = 0; irqn = 0; errn = 0;
        @(negedge clk);
        base_addr = base;
        start_m = 1'b1;
        @(negedge clk);
        start_m = 1'b0;
        if (mid_poke) begin
            repeat (3) @(negedge clk);
            base_addr = 32'h20;
            start_m = 1'b1;
            @(negedge clk);
            start_m = 1'b0;
        end
        for (int i = 0; i < 3000 && dn == 0 && errn == 0; i++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        xfer_done = 1'b0;
        mv_cnt = 0;
        xn = 0; rn = 0; dn = 0; irqn = 0; errn = 0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(!mem_req && !xfer_req, "R1 requests", {mem_req, xfer_req}, 0);
        chk(!done && !dma_irq && !err, "R1 pulses", {done, dma_irq, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 after release", {busy, mem_req}, 0);

        // Table: one descriptor at 0x10
        for (int v = 0; v < 6; v++) begin
            mem[4] = VECS[v].w0;
            mem[5] = VECS[v].w1;
            run_chain(32'h10, 1'b0);
            chk(rn == 2, "R2 read count", rn, 2);
            chk(ra[0] == 32'h10 && ra[1] == 32'h14, "R2 read addresses", ra[1], 32'h14);
            chk(xn == int'(VECS[v].nx), "R7 R10 transfer count", xn, VECS[v].nx);
            if (VECS[v].nx != 0) begin
                chk(xa[0] == VECS[v].w1, "R4 xfer address", xa[0], VECS[v].w1);
                chk(xl[0] == VECS[v].xlen, "R4 xfer length", xl[0], VECS[v].xlen);
            end
            chk(dn == int'(VECS[v].dn), "R8 done count", dn, VECS[v].dn);
            chk(irqn == int'(VECS[v].irq), "R9 irq count", irqn, VECS[v].irq);
            chk(errn == int'(VECS[v].er), "R10 err count", errn, VECS[v].er);
            chk(!busy, "R8 idle after walk", busy, 0);
        end

        // Chain: xfer(int, not final) -> nop -> link 0x30 -> xfer final with int
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0]  = 32'h0008_0025; mem[1]  = 32'h0000_A000;
        mem[2]  = 32'h0000_0001; mem[3]  = 32'h0000_0000;
        mem[4]  = 32'h0000_0031; mem[5]  = 32'h0000_0030;
        mem[12] = 32'h0040_0027; mem[13] = 32'h0000_B000;
        run_chain(32'h0, 1'b1);   // R3: start pulse with base 0x20 mid-walk
        chk(rn == 8, "R3 R5 R6 read count", rn, 8);
        chk(ra[2] == 32'h08, "R5 advance after transfer", ra[2], 32'h08);
        chk(ra[4] == 32'h10, "R5 advance after nop", ra[4], 32'h10);
        chk(ra[6] == 32'h30 && ra[7] == 32'h34, "R6 link target", ra[6], 32'h30);
        chk(xn == 2, "R4 two transfers", xn, 2);
        chk(xa[0] == 32'hA000 && xl[0] == 16'd8, "R4 first transfer", xa[0], 32'hA000);
        chk(xa[1] == 32'hB000 && xl[1] == 16'h40, "R4 second transfer", xa[1], 32'hB000);
        chk(dn == 1, "R8 chain done", dn, 1);
        chk(irqn == 1, "R9 only final irq", irqn, 1);
        chk(errn == 0, "R3 ignored start caused no err", errn, 0);

        // R3: start coinciding with the final xfer_done is ignored
        mem[4] = 32'h0010_0023; mem[5] = 32'h0000_C000;
        poke_on_done = 1'b1;
        run_chain(32'h10, 1'b0);
        poke_on_done = 1'b0;
        chk(rn == 2, "R3 no refetch after coincident start", rn, 2);
        chk(dn == 1 && xn == 1, "R3 single completion", dn, 1);
        chk(!busy, "R3 idle after coincident start", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule